// File: doc/BRIEF.md
# Rectangle Fill Command Engine

The engine lets a processor fill solid rectangles in a frame buffer without writing any pixel itself. Software writes the rectangle's corner, extent and colour into a set of staging registers. A write to the go register takes a snapshot of those fields as one command and places it in a small command queue. Once software has written all the fields it needs, it can trigger more commands at once, up to the queue depth.

A walker takes one command at a time from the head of the queue. It visits every pixel of the rectangle in raster order. For each pixel it offers one write, with a linear frame-buffer address and the colour, on a valid/ready port that leads to frame-buffer memory. A busy output tells software when all queued work has drained. A sticky overflow output records any command that was lost because the queue was full.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy`, `px_valid` and `overflow` are low.
- R2: A register write with `reg_addr` 0 sets x, 1 sets y, 2 sets width, 3 sets height (each taken from the low 10 bits of `reg_wdata`) and 4 sets the 16-bit colour. A write to `reg_addr` 5 enqueues a snapshot of these five fields, and its data is ignored. Register writes made after a trigger do not change a command that is already queued.
- R3: A trigger that arrives while the queue holds FIFO_DEPTH commands is dropped, and `overflow` goes high and stays high until reset.
- R4: A command with width W and height H produces exactly W*H accepted writes, in raster order: the column advances first, then the row.
- R5: Each write carries address ((y+row)*FB_WIDTH + (x+col)) modulo 2^ADDR_W, where ADDR_W = clog2(FB_WIDTH*FB_HEIGHT), and carries the command's colour on `px_data`. No clipping is applied.
- R6: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_addr` and `px_data` stay unchanged into the next cycle.
- R7: Commands are executed one at a time, in the order in which they were triggered.
- R8: A command with zero width or zero height completes without any write.
- R9: `busy` is high from the cycle after a trigger is accepted until the queue is empty and no rectangle is in progress. `px_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| px_valid | output | 1 | Pixel write offered |
| px_ready | input | 1 | Memory accepts the pixel write |
| px_addr | output | ADDR_W (19) | Linear pixel address |
| px_data | output | 16 | Pixel colour |
| busy | output | 1 | Work queued or a rectangle in progress |
| overflow | output | 1 | Sticky: a trigger was dropped |

## Verification
The bench targets rectangles that cross the right edge and bottom edge of the frame. A design that clipped those pixels, or that swapped the row and column order, would show a wrong write count or wrong addresses. Irregular ready patterns check that a stalled write holds steady; a walker that advanced without a handshake would skip pixels. Zero-width and zero-height commands must leave the bus silent, so an off-by-one in the loop end would emit a stray write. Filling the queue behind a stalled walker, while the colour changes between triggers, shows whether the snapshot is taken correctly, whether the queue keeps order, and whether exactly the trigger that did not fit is the one dropped and flagged.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
   localparam int COORD_W = 10;
   localparam int COLOR_W = 16;
   localparam int REG_W   = 16;
   localparam int REG_AW  = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_X     = 3'd0,
      RA_Y     = 3'd1,
      RA_W     = 3'd2,
      RA_H     = 3'd3,
      RA_COLOR = 3'd4,
      RA_GO    = 3'd5
   } reg_sel_e;

   typedef struct packed {
      logic [COORD_W-1:0] x;
      logic [COORD_W-1:0] y;
      logic [COORD_W-1:0] w;
      logic [COORD_W-1:0] h;
      logic [COLOR_W-1:0] color;
   } rect_cmd_t;
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
   import rfe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic              go,
   output rect_cmd_t         staged
);
   // staging fields; a trigger snapshots them combinationally
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_X:     staged.x     <= reg_wdata[COORD_W-1:0];
            RA_Y:     staged.y     <= reg_wdata[COORD_W-1:0];
            RA_W:     staged.w     <= reg_wdata[COORD_W-1:0];
            RA_H:     staged.h     <= reg_wdata[COORD_W-1:0];
            RA_COLOR: staged.color <= reg_wdata[COLOR_W-1:0];
            default:  ;
         endcase
      end
   end

   assign go = reg_we && (reg_addr == RA_GO);
endmodule

// File: rtl/rfe_cmd_fifo.sv
module rfe_cmd_fifo
   import rfe_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  rect_cmd_t push_cmd,
   input  logic      pop,
   output rect_cmd_t head,
   output logic      not_empty,
   output logic      overflow
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   rect_cmd_t          mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]   count;
   logic               full, do_push, do_pop;

   assign full      = (count == CNT_W'(DEPTH));
   assign not_empty = (count != '0);
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;
   assign head      = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_cmd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
         if (push && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
   import rfe_pkg::*;
#(
   parameter int FB_WIDTH = 640,
   parameter int ADDR_W   = 19
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_avail,
   input  rect_cmd_t         cmd_in,
   output logic              cmd_pop,
   output logic              px_valid,
   input  logic              px_ready,
   output logic [ADDR_W-1:0] px_addr,
   output logic [COLOR_W-1:0] px_data,
   output logic              active
);
   localparam int LIN_W = ADDR_W + COORD_W + 2;

   typedef enum logic {WK_IDLE, WK_RUN} wk_state_e;

   wk_state_e          state;
   rect_cmd_t          cur;
   logic [COORD_W-1:0] col, row;
   logic               last_col, last_row;
   logic [COORD_W:0]   col_abs, row_abs;

   assign cmd_pop  = (state == WK_IDLE) && cmd_avail;
   assign last_col = (col == cur.w - 1'b1);
   assign last_row = (row == cur.h - 1'b1);
   assign active   = (state == WK_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WK_IDLE;
         cur   <= '0;
         col   <= '0;
         row   <= '0;
      end else begin
         case (state)
            WK_IDLE: if (cmd_pop) begin
               cur <= cmd_in;
               col <= '0;
               row <= '0;
               if (cmd_in.w != '0 && cmd_in.h != '0) state <= WK_RUN;
            end
            WK_RUN: if (px_ready) begin
               if (last_col) begin
                  col <= '0;
                  if (last_row) state <= WK_IDLE;
                  else          row   <= row + 1'b1;
               end else begin
                  col <= col + 1'b1;
               end
            end
            default: state <= WK_IDLE;
         endcase
      end
   end

   // address is a function of held state only, so it stays put during a stall
   assign col_abs  = {1'b0, cur.x} + {1'b0, col};
   assign row_abs  = {1'b0, cur.y} + {1'b0, row};
   assign px_addr  = ADDR_W'(LIN_W'(row_abs) * LIN_W'(FB_WIDTH) + LIN_W'(col_abs));
   assign px_data  = cur.color;
   assign px_valid = (state == WK_RUN);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
   import rfe_pkg::*;
#(
   parameter  int FB_WIDTH   = 640,
   parameter  int FB_HEIGHT  = 480,
   parameter  int FIFO_DEPTH = 4,
   localparam int ADDR_W     = $clog2(FB_WIDTH * FB_HEIGHT)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic               px_valid,
   input  logic               px_ready,
   output logic [ADDR_W-1:0]  px_addr,
   output logic [COLOR_W-1:0] px_data,
   output logic               busy,
   output logic               overflow
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("rect_fill_engine: FIFO_DEPTH must be at least 2");
      end
      if (FB_WIDTH < 1 || FB_HEIGHT < 1) begin : g_bad_fb
         $error("rect_fill_engine: frame dimensions must be positive");
      end
      if (REG_W < COLOR_W || REG_W < COORD_W) begin : g_bad_reg
         $error("rect_fill_engine: register data narrower than a field");
      end
   endgenerate

   logic      go, q_avail, q_pop, walk_active;
   rect_cmd_t staged, q_head;

   rfe_regs i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .go        (go),
      .staged    (staged)
   );

   rfe_cmd_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (go),
      .push_cmd  (staged),
      .pop       (q_pop),
      .head      (q_head),
      .not_empty (q_avail),
      .overflow  (overflow)
   );

   rfe_walker #(.FB_WIDTH(FB_WIDTH), .ADDR_W(ADDR_W)) i_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_avail (q_avail),
      .cmd_in    (q_head),
      .cmd_pop   (q_pop),
      .px_valid  (px_valid),
      .px_ready  (px_ready),
      .px_addr   (px_addr),
      .px_data   (px_data),
      .active    (walk_active)
   );

   assign busy = q_avail || walk_active;
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker
   import rfe_pkg::*;
#(
   parameter int ADDR_W = 19
)(
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [REG_AW-1:0]  reg_addr,
   input logic               px_valid,
   input logic               px_ready,
   input logic [ADDR_W-1:0]  px_addr,
   input logic [COLOR_W-1:0] px_data,
   input logic               busy,
   input logic               overflow
);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && !px_ready) |=> (px_valid && $stable(px_addr) && $stable(px_data)));

   p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(reg_we && reg_addr == RA_GO));

   p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> busy);

   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && px_ready) |=> (!px_valid || px_addr != $past(px_addr)));
endmodule

bind rect_fill_engine rfe_checker #(.ADDR_W(ADDR_W)) i_rfe_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .px_valid (px_valid),
   .px_ready (px_ready),
   .px_addr  (px_addr),
   .px_data  (px_data),
   .busy     (busy),
   .overflow (overflow)
);

// File: tb/test_rect_fill_engine.sv
module test_rect_fill_engine;
   localparam int FBW   = 640;
   localparam int AW    = 19;
   localparam int DEPTH = 4;
   localparam int NV    = 6;
   localparam int CAP   = 512;

   // {x, y, w, h, colour, ready mode}
   localparam logic [63:0] VEC [NV] = '{
      {10'd5,   10'd3,   10'd4, 10'd2, 16'hF800, 8'd0},
      {10'd638, 10'd478, 10'd4, 10'd3, 16'h07E0, 8'd1},
      {10'd0,   10'd0,   10'd1, 10'd1, 16'hFFFF, 8'd3},
      {10'd100, 10'd200, 10'd0, 10'd5, 16'h1234, 8'd0},
      {10'd7,   10'd9,   10'd6, 10'd0, 16'h4321, 8'd1},
      {10'd0,   10'd479, 10'd8, 10'd1, 16'hA5A5, 8'd3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic          px_valid, px_ready = 1'b0, busy, overflow;
   logic [AW-1:0] px_addr;
   logic [15:0]   px_data;

   int          n_chk = 0, n_bad = 0, cap_n = 0, rdy_mode = 0, cyc = 0;
   bit          finished = 1'b0;
   logic [AW-1:0] cap_addr [CAP];
   logic [15:0]   cap_data [CAP];

   always #5 clk = ~clk;

   rect_fill_engine i_rect_fill_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .px_valid(px_valid), .px_ready(px_ready),
      .px_addr(px_addr), .px_data(px_data), .busy(busy), .overflow(overflow)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr(input int x, input int y, input int r, input int c);
      return ((y + r) * FBW + x + c) % (1 << AW);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
   endtask

   // ready driver and write monitor, both at the falling edge
   initial begin
      bit            stall_prev = 1'b0;
      logic [AW-1:0] a_prev = '0;
      logic [15:0]   d_prev = '0;
      forever begin
         @(negedge clk);
         cyc++;
         case (rdy_mode)
            0:       px_ready = 1'b1;
            1:       px_ready = cyc[0];
            2:       px_ready = 1'b0;
            default: px_ready = (cyc % 3) != 0;
         endcase
         if (stall_prev && rst_n) begin
            chk("R6", "valid held", px_valid, 1);
            chk("R6", "addr held", px_addr, a_prev);
            chk("R6", "data held", px_data, d_prev);
         end
         stall_prev = px_valid && !px_ready;
         a_prev = px_addr;
         d_prev = px_data;
         if (px_valid && px_ready && cap_n < CAP) begin
            cap_addr[cap_n] = px_addr;
            cap_data[cap_n] = px_data;
            cap_n++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "px_valid after reset", px_valid, 0);
      chk("R1", "overflow after reset", overflow, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         int x, y, w, h, col, m;
         x   = int'(VEC[v][63:54]);
         y   = int'(VEC[v][53:44]);
         w   = int'(VEC[v][43:34]);
         h   = int'(VEC[v][33:24]);
         col = int'(VEC[v][23:8]);
         m   = int'(VEC[v][7:0]);
         rdy_mode = m;
         cap_n = 0;
         wr(3'd0, 16'(x));
         wr(3'd1, 16'(y));
         wr(3'd2, 16'(w));
         wr(3'd3, 16'(h));
         wr(3'd4, 16'(col));
         wr(3'd5, 16'hDEAD);
         chk("R9", "busy after trigger", busy, 1);
         wait_idle();
         chk("R9", "valid low when idle", px_valid, 0);
         if (w == 0 || h == 0) chk("R8", "writes for empty rect", cap_n, 0);
         else                  chk("R4", "write count", cap_n, w * h);
         for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
               if (r * w + c < cap_n) begin
                  chk("R5", "pixel address", cap_addr[r * w + c], exp_addr(x, y, r, c));
                  chk("R5", "pixel colour", cap_data[r * w + c], col);
               end
      end

      // queue fill behind a stalled walker, colour changed between triggers
      rdy_mode = 2;
      cap_n = 0;
      wr(3'd0, 16'd2);
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd1);
      wr(3'd3, 16'd1);
      wr(3'd4, 16'h1000);
      wr(3'd5, 16'h0);
      repeat (3) @(negedge clk);
      chk("R6", "stalled write offered", px_valid, 1);
      for (int k = 1; k <= DEPTH; k++) begin
         wr(3'd4, 16'(16'h1000 + k));
         wr(3'd5, 16'h0);
      end
      chk("R3", "no overflow at full", overflow, 0);
      chk("R9", "busy while queued", busy, 1);
      wr(3'd4, 16'h2000);
      wr(3'd5, 16'h0);
      chk("R3", "overflow on drop", overflow, 1);
      rdy_mode = 0;
      wait_idle();
      chk("R3", "accepted commands", cap_n, DEPTH + 1);
      for (int k = 0; k <= DEPTH; k++) begin
         chk("R7", "queue order colour", cap_data[k], 16'h1000 + k);
         chk("R2", "snapshot address", cap_addr[k], exp_addr(2, 2, 0, 0));
      end
      chk("R3", "overflow sticky", overflow, 1);
      chk("R9", "idle after drain", busy, 0);

      // reset clears the sticky flag
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "overflow cleared by reset", overflow, 0);
      chk("R1", "busy after second reset", busy, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule